// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a bank of PWM generators and the output pins. It gathers several fault sources, decides for each generator whether that generator must stop, and while the stop holds it replaces the generator's two waveform outputs with programmed safe levels. The fault sources are four external fault pins, a debug halt request, and a trigger from an analog-to-digital comparator. Each pin has its own active level. Each generator has its own enable mask over all six sources, so one stall can shut down some generators and leave others running.

The external pins are asynchronous. They are first adjusted for their active level and then pass through a synchronizer. The halt request and the comparator trigger come from the block's own clock domain and act in the same cycle. Each generator also keeps a latched fault flag, so that software can see that a fault happened even after the fault has cleared.

Top module: `pwm_fault_guard`

## Requirements
- R1: An external fault pin reaches the fault decision through two register stages. After a pin changes, the generator outputs do not react at the first rising clock edge. They react at the second edge, both when the fault starts and when it ends.
- R2: Bit p of `pin_active_low_i` sets the active level of pin p. A value of 1 means a low pin signals a fault. A value of 0 means a high pin signals a fault.
- R3: Generator g takes its source mask from `src_enable_i[6g+5:6g]`. Bits 0 to 3 enable fault pins 0 to 3, bit 4 enables the debug halt and bit 5 enables the comparator trigger. The generator's fault condition is the OR of its enabled, active sources.
- R4: An enabled debug halt or comparator trigger drives the generator's fault condition high in the same cycle, with no register in between.
- R5: While generator g is in fault, `pwm_a_o[g]` equals `safe_level_i[2g]` and `pwm_b_o[g]` equals `safe_level_i[2g+1]`.
- R6: While generator g is not in fault, `pwm_a_o[g]` and `pwm_b_o[g]` follow `pwm_a_i[g]` and `pwm_b_i[g]`. Active sources whose mask bit is 0 have no effect.
- R7: `fault_active_o[g]` shows the current fault condition of generator g.
- R8: `fault_sticky_o[g]` becomes 1 at the clock edge after the fault condition of generator g is seen high. It then stays 1 after the fault ends.
- R9: Driving `status_clr_i[g]` high for one cycle clears `fault_sticky_o[g]` at that edge. If the fault condition is still high at the same edge, the flag stays 1.
- R10: After synchronous reset, all sticky flags are 0 and the pin synchronizers hold the no-fault level. The outputs therefore follow the PWM inputs.
- R11: Generators are independent. A fault on one generator does not change the outputs, fault indication or sticky flag of another generator whose mask excludes that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pin_i | input | NUM_PINS | Asynchronous external fault pins |
| dbg_stall_i | input | 1 | Debug halt request, same clock domain |
| adc_trig_i | input | 1 | Comparator trigger, same clock domain |
| pin_active_low_i | input | NUM_PINS | Active level per pin, 1 = active low |
| src_enable_i | input | NUM_GEN*(NUM_PINS+2) | Source mask per generator |
| safe_level_i | input | 2*NUM_GEN | Safe levels per generator, A in the even bit and B in the odd bit |
| pwm_a_i | input | NUM_GEN | Waveform A from each generator |
| pwm_b_i | input | NUM_GEN | Waveform B from each generator |
| status_clr_i | input | NUM_GEN | Write-one-to-clear strobe for the sticky flags |
| pwm_a_o | output | NUM_GEN | Guarded waveform A |
| pwm_b_o | output | NUM_GEN | Guarded waveform B |
| fault_active_o | output | NUM_GEN | Current fault condition per generator |
| fault_sticky_o | output | NUM_GEN | Latched fault flag per generator |

## Verification
The assertions check on every cycle that the outputs match either the safe levels or the live waveforms, depending on the fault indication. They also check that an enabled halt or trigger forces a fault at once, that a pin held active two edges ago forces a fault, and that the sticky flag sets, holds and clears as the rules say. Only the bench scenarios can show the exact edge at which a pin fault starts and ends. The same holds for the effect of each active level and mask bit, and for whether one generator's fault stays out of the others.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    // Non-pin sources appended above the pin bits: halt, then comparator.
    localparam int EXTRA_SRC = 2;
    localparam int HALT_OFS  = 0;
    localparam int TRIG_OFS  = 1;

    typedef struct packed {
        logic b;
        logic a;
    } pwm_pair_t;

    // Output selection for one generator.
    function automatic pwm_pair_t pick_output(input pwm_pair_t live,
                                              input pwm_pair_t safe,
                                              input logic      fault);
        return fault ? safe : live;
    endfunction

endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_fault_gen.sv
module pwm_fault_gen
    import pwm_fault_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] src_en_i,
    input  pwm_pair_t       live_i,
    input  pwm_pair_t       safe_i,
    input  logic            clr_i,
    output pwm_pair_t       out_o,
    output logic            fault_o,
    output logic            sticky_o
);
    logic fault;
    logic sticky_q;

    assign fault = |(src_i & src_en_i);

    // Set has priority over the clear strobe.
    always_ff @(posedge clk) begin
        if (rst) sticky_q <= 1'b0;
        else     sticky_q <= fault | (sticky_q & ~clr_i);
    end

    assign out_o    = pick_output(live_i, safe_i, fault);
    assign fault_o  = fault;
    assign sticky_o = sticky_q;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pwm_fault_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int NUM_GEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NUM_PINS-1:0]                    fault_pin_i,
    input  logic                                   dbg_stall_i,
    input  logic                                   adc_trig_i,
    input  logic [NUM_PINS-1:0]                    pin_active_low_i,
    input  logic [NUM_GEN*(NUM_PINS+EXTRA_SRC)-1:0] src_enable_i,
    input  logic [2*NUM_GEN-1:0]                   safe_level_i,
    input  logic [NUM_GEN-1:0]                     pwm_a_i,
    input  logic [NUM_GEN-1:0]                     pwm_b_i,
    input  logic [NUM_GEN-1:0]                     status_clr_i,
    output logic [NUM_GEN-1:0]                     pwm_a_o,
    output logic [NUM_GEN-1:0]                     pwm_b_o,
    output logic [NUM_GEN-1:0]                     fault_active_o,
    output logic [NUM_GEN-1:0]                     fault_sticky_o
);
    localparam int NSRC = NUM_PINS + EXTRA_SRC;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NSRC-1:0]     src_vec;

    // Active level applied first, so a cleared synchronizer means no fault.
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic active_lvl;
            assign active_lvl = fault_pin_i[p] ^ pin_active_low_i[p];
            pwm_fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d_i (active_lvl),
                .q_o (pin_sync[p])
            );
        end
    endgenerate

    assign src_vec[NUM_PINS-1:0]       = pin_sync;
    assign src_vec[NUM_PINS+HALT_OFS]  = dbg_stall_i;
    assign src_vec[NUM_PINS+TRIG_OFS]  = adc_trig_i;

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
            pwm_pair_t live, safe, outp;
            assign live.a = pwm_a_i[g];
            assign live.b = pwm_b_i[g];
            assign safe.a = safe_level_i[2*g];
            assign safe.b = safe_level_i[2*g+1];

            pwm_fault_gen #(.NSRC(NSRC)) u_gen (
                .clk      (clk),
                .rst      (rst),
                .src_i    (src_vec),
                .src_en_i (src_enable_i[g*NSRC +: NSRC]),
                .live_i   (live),
                .safe_i   (safe),
                .clr_i    (status_clr_i[g]),
                .out_o    (outp),
                .fault_o  (fault_active_o[g]),
                .sticky_o (fault_sticky_o[g])
            );

            assign pwm_a_o[g] = outp.a;
            assign pwm_b_o[g] = outp.b;
        end
    endgenerate
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk
    import pwm_fault_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int NUM_GEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [NUM_PINS-1:0]                    fault_pin_i,
    input logic                                   dbg_stall_i,
    input logic                                   adc_trig_i,
    input logic [NUM_PINS-1:0]                    pin_active_low_i,
    input logic [NUM_GEN*(NUM_PINS+EXTRA_SRC)-1:0] src_enable_i,
    input logic [2*NUM_GEN-1:0]                   safe_level_i,
    input logic [NUM_GEN-1:0]                     pwm_a_i,
    input logic [NUM_GEN-1:0]                     pwm_b_i,
    input logic [NUM_GEN-1:0]                     status_clr_i,
    input logic [NUM_GEN-1:0]                     pwm_a_o,
    input logic [NUM_GEN-1:0]                     pwm_b_o,
    input logic [NUM_GEN-1:0]                     fault_active_o,
    input logic [NUM_GEN-1:0]                     fault_sticky_o
);
    localparam int NSRC = NUM_PINS + EXTRA_SRC;

    // Cycles since reset, saturating, guards the history-based check.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= 2'd0;
        else if (age_q != 3)  age_q <= age_q + 2'd1;
    end

    logic [NUM_PINS-1:0] lvl;
    assign lvl = fault_pin_i ^ pin_active_low_i;

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
            p_halt_forces_r4: assert property (@(posedge clk) disable iff (rst)
                (dbg_stall_i && src_enable_i[g*NSRC+NUM_PINS+HALT_OFS]) |-> fault_active_o[g]);
            p_trig_forces_r4: assert property (@(posedge clk) disable iff (rst)
                (adc_trig_i && src_enable_i[g*NSRC+NUM_PINS+TRIG_OFS]) |-> fault_active_o[g]);
            p_safe_levels_r5: assert property (@(posedge clk) disable iff (rst)
                fault_active_o[g] |-> (pwm_a_o[g] == safe_level_i[2*g] &&
                                       pwm_b_o[g] == safe_level_i[2*g+1]));
            p_pass_live_r6: assert property (@(posedge clk) disable iff (rst)
                !fault_active_o[g] |-> (pwm_a_o[g] == pwm_a_i[g] && pwm_b_o[g] == pwm_b_i[g]));
            p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
                fault_active_o[g] |=> fault_sticky_o[g]);
            p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
                (fault_sticky_o[g] && !status_clr_i[g]) |=> fault_sticky_o[g]);
            p_sticky_clear_r9: assert property (@(posedge clk) disable iff (rst)
                (status_clr_i[g] && !fault_active_o[g]) |=> !fault_sticky_o[g]);
            p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
                (status_clr_i[g] && fault_active_o[g]) |=> fault_sticky_o[g]);

            if (SYNC_STAGES == 2) begin : g_lat
                for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
                    p_pin_latency_r1: assert property (@(posedge clk) disable iff (rst)
                        (age_q == 2'd3 && $past(lvl[p], 2) && src_enable_i[g*NSRC+p])
                        |-> fault_active_o[g]);
                end
            end
        end
    endgenerate
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(
    .NUM_PINS    (NUM_PINS),
    .NUM_GEN     (NUM_GEN),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/pwm_fault_guard_tb.sv
module pwm_fault_guard_tb;
    localparam int NP = 4;
    localparam int NG = 4;
    localparam int NS = NP + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   pins = '0;
    logic            stall = 1'b0;
    logic            trig = 1'b0;
    logic [NP-1:0]   actlo = '0;
    logic [NG*NS-1:0] src_en = '0;
    logic [2*NG-1:0] safe = '0;
    logic [NG-1:0]   pa = '0, pb = '0, clr = '0;
    logic [NG-1:0]   oa, ob, fact, fstk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_fault_guard #(.NUM_PINS(NP), .NUM_GEN(NG), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .fault_pin_i(pins), .dbg_stall_i(stall),
        .adc_trig_i(trig), .pin_active_low_i(actlo), .src_enable_i(src_en),
        .safe_level_i(safe), .pwm_a_i(pa), .pwm_b_i(pb), .status_clr_i(clr),
        .pwm_a_o(oa), .pwm_b_o(ob), .fault_active_o(fact), .fault_sticky_o(fstk)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0] pins;
        logic       stall;
        logic       trig;
        logic [3:0] actlo;
        logic [5:0] mask;
        logic [1:0] safe;   // {B, A}
        logic       pa;
        logic       pb;
        logic       ea;
        logic       eb;
        logic       ef;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 1'b0, 1'b0, 4'b0000, 6'b111111, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'b0001, 1'b0, 1'b0, 4'b0000, 6'b000001, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{4'b0001, 1'b0, 1'b0, 4'b0000, 6'b000010, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'b0100, 1'b0, 1'b0, 4'b0100, 6'b000100, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'b0000, 1'b0, 1'b0, 4'b0100, 6'b000100, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{4'b0000, 1'b1, 1'b0, 4'b0000, 6'b010000, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{4'b0000, 1'b1, 1'b0, 4'b0000, 6'b100000, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'b0000, 1'b0, 1'b1, 4'b0000, 6'b100000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'b1000, 1'b0, 1'b0, 4'b0000, 6'b001000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{4'b1111, 1'b0, 1'b0, 4'b1111, 6'b001111, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : stim
        // R10: reset state
        pa = 4'b1010; pb = 4'b0101;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 sticky after reset", {28'd0, fstk}, 32'd0);
        check("R10 fault after reset", {28'd0, fact}, 32'd0);
        check("R10 outputs pass", {24'd0, oa, ob}, {24'd0, 4'b1010, 4'b0101});

        // Table: generator 0 configured per vector, others masked off
        for (int i = 0; i < NV; i++) begin
            pins  = VECS[i].pins;
            stall = VECS[i].stall;
            trig  = VECS[i].trig;
            actlo = VECS[i].actlo;
            src_en = '0;
            src_en[5:0] = VECS[i].mask;
            safe = {NG{2'b11}};
            safe[1:0] = VECS[i].safe;
            pa = {NG{VECS[i].pa}};
            pb = {NG{VECS[i].pb}};
            repeat (3) @(negedge clk);
            check($sformatf("R2 R3 R5 R6 vector %0d out", i),
                  {30'd0, oa[0], ob[0]}, {30'd0, VECS[i].ea, VECS[i].eb});
            check($sformatf("R7 vector %0d fault", i), {31'd0, fact[0]}, {31'd0, VECS[i].ef});
            check($sformatf("R11 vector %0d other gens pass", i),
                  {24'd0, oa[NG-1:1], 1'b0, ob[NG-1:1], 1'b0}, {24'd0, pa[NG-1:1], 1'b0, pb[NG-1:1], 1'b0});
        end
        check("R8 gen0 sticky after table", {31'd0, fstk[0]}, 32'd1);
        check("R11 other gens sticky untouched", {28'd0, fstk[NG-1:1], 1'b0}, 32'd0);

        // Idle, then clear gen0 sticky
        pins = '0; stall = 1'b0; trig = 1'b0; actlo = '0; src_en = '0;
        pa = '0; pb = '0;
        repeat (3) @(negedge clk);
        clr = 4'b0001;
        @(negedge clk);
        clr = '0;
        check("R9 clear sticky", {31'd0, fstk[0]}, 32'd0);

        // R1 latency on pin 0, gen0 safe levels 11
        src_en[5:0] = 6'b000001;
        safe[1:0] = 2'b11;
        repeat (2) @(negedge clk);
        pins[0] = 1'b1;
        @(negedge clk);
        check("R1 no reaction after one edge", {30'd0, fact[0], oa[0]}, 32'd0);
        @(negedge clk);
        check("R1 fault after two edges", {31'd0, fact[0]}, 32'd1);
        check("R5 safe levels during pin fault", {30'd0, oa[0], ob[0]}, 32'd3);
        check("R8 sticky not yet set", {31'd0, fstk[0]}, 32'd0);
        @(negedge clk);
        check("R8 sticky set one edge later", {31'd0, fstk[0]}, 32'd1);
        pins[0] = 1'b0;
        @(negedge clk);
        check("R1 fault held one edge after release", {31'd0, fact[0]}, 32'd1);
        @(negedge clk);
        check("R1 fault ends at second edge", {31'd0, fact[0]}, 32'd0);
        check("R6 outputs resume", {30'd0, oa[0], ob[0]}, 32'd0);
        check("R8 sticky holds after fault", {31'd0, fstk[0]}, 32'd1);

        // R4 and R9: halt acts at once, set wins over clear
        src_en[5:0] = 6'b010000;
        stall = 1'b1;
        clr = 4'b0001;
        #1;
        check("R4 halt same cycle", {31'd0, fact[0]}, 32'd1);
        @(negedge clk);
        clr = '0;
        check("R9 set wins over clear", {31'd0, fstk[0]}, 32'd1);
        stall = 1'b0;
        #1;
        check("R4 halt release same cycle", {31'd0, fact[0]}, 32'd0);
        clr = 4'b0001;
        @(negedge clk);
        clr = '0;
        check("R9 clear after fault gone", {31'd0, fstk[0]}, 32'd0);

        // R11: comparator on gen1 only
        src_en = '0;
        src_en[NS +: NS] = 6'b100000;
        safe[3:2] = 2'b10;
        pa = '1; pb = '0;
        trig = 1'b1;
        #1;
        check("R4 trigger same cycle gen1", {31'd0, fact[1]}, 32'd1);
        check("R5 gen1 safe levels", {30'd0, oa[1], ob[1]}, 32'd1);
        check("R11 gen2 unaffected", {29'd0, fact[2], oa[2], ob[2]}, 32'd2);
        check("R6 masked trigger ignored on gen0", {30'd0, fact[0], oa[0]}, 32'd1);
        @(negedge clk);
        trig = 1'b0;
        check("R11 only gen1 sticky", {28'd0, fstk}, 32'd2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule